// File: doc/BRIEF.md
# Acknowledged Serial Byte Link

This block moves bytes in both directions over a pair of single-bit wires: one output line that it drives and one input line driven by a partner of the same kind. Each byte it sends travels in an eleven-bit data packet, and the partner answers every byte with a two-bit acknowledge packet on the opposite wire. The transmit side therefore has at most one unacknowledged byte in flight. The same output line also carries the acknowledges for bytes that this end has received, slotted in between data packets.

On the user side there is a valid/ready byte port for transmit and another for receive. A received byte stays in a one-entry buffer until the user takes it, and only then does the block send the acknowledge that lets the partner send its next byte. The partner can therefore never overrun the buffer. A rate input selects a fast bit rate or one exactly half as fast, and both ends must use the same setting. The input line is asynchronous to the local clock. It passes through a two-flop synchronizer and is sampled eight times per bit period, and a start is recognised by the first sample that shows a low-to-high change.

Top module: `ack_byte_link`

## Requirements
- R1: While rst_n is low, link_out is low. After reset, link_out stays low while no packet is being sent, tx_ready is 1 and rx_valid is 0.
- R2: A data packet on link_out is 11 bit periods: 1, 1, then tx_data bit 0 through bit 7 (least significant first), then a 0 stop bit. The line returns low after it.
- R3: An acknowledge packet on link_out is one bit period high followed by one bit period low, after which the line stays low.
- R4: tx_ready is 1 exactly when no accepted byte is awaiting its acknowledge. After a byte is accepted (tx_valid and tx_ready high at a clock edge), tx_ready is 0 and no further data packet starts until an acknowledge packet (1 then 0) has been received on link_in. tx_ready then returns to 1.
- R5: With fast_rate = 1 one bit period is 8*BASE_DIV clocks. With fast_rate = 0 it is 16*BASE_DIV clocks. With the default BASE_DIV = 1 these are 8 and 16 clocks.
- R6: A data packet received on link_in appears on rx_data with rx_valid = 1. Both hold unchanged until a clock edge with rx_ready = 1, after which rx_valid is 0.
- R7: An acknowledge is sent for a received byte only after that byte has been taken from rx_data. No acknowledge packet starts while rx_valid is 1.
- R8: A data packet that has started is always sent to the end. An acknowledge that becomes due meanwhile is sent after it. When both are due at once, the acknowledge goes first.
- R9: Reception works for any phase of link_in relative to the clock. Each bit is taken near the middle of its period, counted from the sample that first sees the line high after a low sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fast_rate | input | 1 | 1 selects the fast bit rate, 0 the half rate |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmit byte can be accepted |
| rx_valid | output | 1 | Received byte available |
| rx_data | output | 8 | Received byte |
| rx_ready | input | 1 | User takes the received byte |
| link_in | input | 1 | Serial input from the partner, asynchronous |
| link_out | output | 1 | Serial output to the partner |

## Verification
The embedded properties watch, on every cycle, the ordering rules:
- the last bit of any packet is low;
- a started packet is never cut short;
- an acknowledge never starts while a received byte is still unread;
- the receive buffer is never written while full and holds steady under back-pressure;
- a data launch only ever belongs to an unacknowledged accepted byte;
- each receive sample lands where the input has been stable for a clock.

Only the bench scenarios can show the things that need a model of the partner. These are the packet contents and bit widths seen at the line, the byte values recovered at different input phases and both rates, and the release of tx_ready by an incoming acknowledge. They also cover an acknowledge waiting behind a data packet already on the wire.

// File: rtl/abl_pkg.sv
package abl_pkg;

  localparam int SAMPLES_PER_BIT = 8;
  localparam int DATA_PKT_BITS   = 11;
  localparam int ACK_PKT_BITS    = 2;
  localparam int PKT_W           = DATA_PKT_BITS;

  // Packet images are shifted out from bit 0 upwards.
  function automatic logic [PKT_W-1:0] data_packet(input logic [7:0] b);
    return {1'b0, b, 1'b1, 1'b1};
  endfunction

  function automatic logic [PKT_W-1:0] ack_packet();
    return {{(PKT_W-2){1'b0}}, 1'b0, 1'b1};
  endfunction

  // Terminal count of the sample-tick divider for the selected rate.
  function automatic int unsigned tick_last(input logic fast, input int unsigned base);
    return fast ? (base - 1) : (2 * base - 1);
  endfunction

  // Clocks in one bit period, written for anyone restating the timing.
  function automatic int unsigned bit_clocks(input logic fast, input int unsigned base);
    return (tick_last(fast, base) + 1) * SAMPLES_PER_BIT;
  endfunction

endpackage

// File: rtl/abl_tick.sv
module abl_tick #(
  parameter int BASE_DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast,
  output logic tick
);
  localparam int CW = $clog2(2 * BASE_DIV) + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last = CW'(abl_pkg::tick_last(fast, BASE_DIV));
  assign tick = (cnt >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/abl_tx.sv
module abl_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       req_ack,
  input  logic       req_data,
  input  logic [7:0] data,
  output logic       line,
  output logic       launch_ack,
  output logic       launch_data
);
  import abl_pkg::*;

  logic             busy;
  logic [PKT_W-1:0] sh;
  logic [3:0]       left;
  logic [2:0]       sub;
  logic             bit_end;
  logic             pkt_end;

  assign launch_ack  = tick && !busy && req_ack;
  assign launch_data = tick && !busy && !req_ack && req_data;
  assign bit_end     = busy && tick && (sub == 3'(SAMPLES_PER_BIT - 1));
  assign pkt_end     = bit_end && (left == 4'd1);
  assign line        = busy & sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sh   <= '0;
      left <= '0;
      sub  <= '0;
    end else if (launch_ack) begin
      busy <= 1'b1;
      sh   <= ack_packet();
      left <= 4'(ACK_PKT_BITS);
      sub  <= '0;
    end else if (launch_data) begin
      busy <= 1'b1;
      sh   <= data_packet(data);
      left <= 4'(DATA_PKT_BITS);
      sub  <= '0;
    end else if (bit_end) begin
      sh   <= sh >> 1;
      sub  <= '0;
      left <= left - 1'b1;
      if (pkt_end) busy <= 1'b0;
    end else if (busy && tick) begin
      sub <= sub + 1'b1;
    end
  end

  // R2 / R3: every packet ends on a low bit.
  assert_last_bit_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && left == 4'd1) |-> !line);

  // R8: a packet in progress keeps going until its final bit ends.
  assert_no_preempt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pkt_end) |=> (busy && !launch_ack && !launch_data));
endmodule

// File: rtl/abl_rx.sv
module abl_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line_async,
  output logic       byte_done,
  output logic       ack_seen,
  output logic [7:0] byte_q
);
  import abl_pkg::*;

  localparam logic [3:0] FIRST_WAIT = 4'(SAMPLES_PER_BIT + SAMPLES_PER_BIT / 2 - 1);
  localparam logic [3:0] NEXT_WAIT  = 4'(SAMPLES_PER_BIT - 1);

  logic [1:0] sy;
  logic       s;
  logic       prev;
  logic       run;
  logic [3:0] cnt;
  logic [3:0] idx;
  logic [6:0] sr;
  logic       rise;
  logic       sample;

  assign s      = sy[1];
  assign rise   = tick && !run && s && !prev;
  assign sample = tick && run && (cnt == 4'd0);

  assign ack_seen  = sample && (idx == 4'd0) && !s;
  assign byte_done = sample && (idx == 4'd8);
  assign byte_q    = {s, sr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy   <= '0;
      prev <= 1'b0;
      run  <= 1'b0;
      cnt  <= '0;
      idx  <= '0;
      sr   <= '0;
    end else begin
      sy <= {sy[0], line_async};
      if (tick) prev <= s;
      if (rise) begin
        run <= 1'b1;
        cnt <= FIRST_WAIT;
        idx <= '0;
      end else if (sample) begin
        cnt <= NEXT_WAIT;
        if (idx == 4'd0) begin
          if (!s) run <= 1'b0;
          else    idx <= 4'd1;
        end else if (idx == 4'd8) begin
          run <= 1'b0;
        end else begin
          sr  <= {s, sr[6:1]};
          idx <= idx + 1'b1;
        end
      end else if (run && tick) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  // R9: each bit is taken where the synchronized line has been steady.
  assert_mid_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sample |-> (s == $past(s)));
endmodule

// File: rtl/ack_byte_link.sv
module ack_byte_link #(
  parameter int BASE_DIV = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fast_rate,
  input  logic       tx_valid,
  input  logic [7:0] tx_data,
  output logic       tx_ready,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  input  logic       rx_ready,
  input  logic       link_in,
  output logic       link_out
);
  logic       tick;
  logic       launch_ack;
  logic       launch_data;
  logic       byte_done;
  logic       ack_seen;
  logic [7:0] byte_q;

  logic [7:0] hold_q;
  logic       hold_full;
  logic       outstanding;
  logic       ack_pend;
  logic       rx_full;
  logic [7:0] rx_q;
  logic       accept;
  logic       drain;

  assign accept   = tx_valid && !outstanding;
  assign drain    = rx_full && rx_ready;
  assign tx_ready = !outstanding;
  assign rx_valid = rx_full;
  assign rx_data  = rx_q;

  abl_tick #(.BASE_DIV(BASE_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .fast(fast_rate), .tick(tick)
  );

  abl_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .req_ack(ack_pend), .req_data(hold_full), .data(hold_q),
    .line(link_out), .launch_ack(launch_ack), .launch_data(launch_data)
  );

  abl_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_async(link_in),
    .byte_done(byte_done), .ack_seen(ack_seen), .byte_q(byte_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q      <= '0;
      hold_full   <= 1'b0;
      outstanding <= 1'b0;
    end else begin
      if (accept) begin
        hold_q      <= tx_data;
        hold_full   <= 1'b1;
        outstanding <= 1'b1;
      end
      if (launch_data) hold_full <= 1'b0;
      if (ack_seen && outstanding && !hold_full) outstanding <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full  <= 1'b0;
      rx_q     <= '0;
      ack_pend <= 1'b0;
    end else begin
      if (launch_ack) ack_pend <= 1'b0;
      if (drain) begin
        rx_full  <= 1'b0;
        ack_pend <= 1'b1;
      end
      if (byte_done && !rx_full) begin
        rx_full <= 1'b1;
        rx_q    <= byte_q;
      end
    end
  end

  assert_ack_after_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    launch_ack |-> !rx_full);

  assert_no_overwrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> !rx_full);

  assert_rx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  assert_one_in_flight_R4: assert property (@(posedge clk) disable iff (!rst_n)
    launch_data |-> (outstanding && !tx_ready));
endmodule

// File: tb/ack_byte_link_bench.sv
module ack_byte_link_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fast_rate = 1'b1;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_ready;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       rx_ready = 1'b0;
  logic       link_in = 1'b0;
  logic       link_out;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  ack_byte_link u_ack_byte_link (
    .clk(clk), .rst_n(rst_n), .fast_rate(fast_rate),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .link_in(link_in), .link_out(link_out)
  );

  // {fast, byte sent by the block, byte sent to the block, input phase offset}
  localparam int NV = 6;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 8'hA6, 8'h3C, 4'd0},
    {1'b1, 8'h01, 8'hFE, 4'd3},
    {1'b0, 8'h80, 8'h55, 4'd5},
    {1'b0, 8'hFF, 8'h00, 4'd11},
    {1'b1, 8'h00, 8'hB7, 4'd7},
    {1'b0, 8'h69, 8'h92, 4'd2}
  };

  function automatic int bit_len(input logic f);
    return f ? 8 : 16;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive_pkt(input logic [10:0] p, input int n, input int bc);
    for (int i = 0; i < n; i++) begin
      link_in = p[i];
      repeat (bc) @(negedge clk);
    end
    link_in = 1'b0;
  endtask

  task automatic wait_rise(output bit found);
    int w = 0;
    while (!link_out && w < 4000) begin
      @(negedge clk);
      w++;
    end
    found = link_out;
  endtask

  task automatic capture(input int bc, output bit found, output bit is_ack,
                         output logic [7:0] d, output bit stop_ok);
    logic b0, b1;
    d = 8'h00; is_ack = 1'b0; stop_ok = 1'b0;
    wait_rise(found);
    if (found) begin
      repeat (bc / 2) @(negedge clk);
      b0 = link_out;
      repeat (bc) @(negedge clk);
      b1 = link_out;
      if (!b0) found = 1'b0;
      if (!b1) begin
        is_ack = 1'b1;
      end else begin
        for (int i = 0; i < 8; i++) begin
          repeat (bc) @(negedge clk);
          d[i] = link_out;
        end
        repeat (bc) @(negedge clk);
        stop_ok = !link_out;
      end
    end
  endtask

  task automatic measure_high(output int width);
    bit found;
    width = 0;
    wait_rise(found);
    if (found) begin
      while (link_out && width < 1000) begin
        width++;
        @(negedge clk);
      end
    end
  endtask

  task automatic stays_low(input int n, output bit low);
    low = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (link_out) low = 1'b0;
    end
  endtask

  task automatic wait_rx();
    int w = 0;
    while (!rx_valid && w < 400) begin
      @(negedge clk);
      w++;
    end
  endtask

  task automatic take_rx();
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired, R4 R8 flow hung actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    bit found, is_ack, stop_ok, low;
    logic [7:0] d;
    int width, bc;

    // R1: reset state.
    link_in = 1'b1;
    repeat (3) @(negedge clk);
    chk(link_out == 1'b0, "R1 link_out in reset", link_out, 0);
    link_in = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(link_out == 1'b0 && tx_ready && !rx_valid, "R1 post-reset outputs",
        {link_out, tx_ready, rx_valid}, 3'b010);
    stays_low(40, low);
    chk(low, "R1 idle line low", !low, 0);

    // Table walk: both directions, both rates, varied input phase.
    for (int v = 0; v < NV; v++) begin
      logic [7:0] tb, rb;
      int off;
      fast_rate = VEC[v][20];
      tb  = VEC[v][19:12];
      rb  = VEC[v][11:4];
      off = int'(VEC[v][3:0]);
      bc  = bit_len(fast_rate);
      repeat (3) @(negedge clk);

      tx_data = tb; tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      chk(!tx_ready, "R4 ready drops after accept", tx_ready, 0);
      capture(bc, found, is_ack, d, stop_ok);
      chk(found && !is_ack && d == tb && stop_ok, "R2 R5 data packet", d, tb);

      repeat (off) @(negedge clk);
      drive_pkt({1'b0, rb, 2'b11}, 11, bc);
      wait_rx();
      chk(rx_valid && rx_data == rb, "R6 R9 received byte", rx_data, rb);
      stays_low(3 * bc, low);
      chk(low && rx_valid && rx_data == rb, "R7 no ack while unread", !low, 0);

      take_rx();
      chk(!rx_valid, "R6 valid clears on take", rx_valid, 0);
      measure_high(width);
      chk(width == bc, "R3 R5 ack high width", width, bc);
      stays_low(2 * bc, low);
      chk(low, "R3 ack low bit then idle", !low, 0);

      chk(!tx_ready, "R4 still waiting for ack", tx_ready, 0);
      repeat (off) @(negedge clk);
      drive_pkt(11'b01, 2, bc);
      repeat (4) @(negedge clk);
      chk(tx_ready, "R4 ready after ack", tx_ready, 1);
    end

    // R4: a second offered byte waits for the acknowledge.
    fast_rate = 1'b1;
    bc = bit_len(1'b1);
    repeat (3) @(negedge clk);
    tx_data = 8'h5A; tx_valid = 1'b1;
    @(negedge clk);
    tx_data = 8'hC3;
    capture(bc, found, is_ack, d, stop_ok);
    chk(found && !is_ack && d == 8'h5A, "R4 first byte", d, 8'h5A);
    stays_low(5 * bc, low);
    chk(low && !tx_ready, "R4 no second packet before ack", {!low, tx_ready}, 0);
    drive_pkt(11'b01, 2, bc);
    capture(bc, found, is_ack, d, stop_ok);
    tx_valid = 1'b0;
    chk(found && !is_ack && d == 8'hC3 && stop_ok, "R4 second byte after ack", d, 8'hC3);
    drive_pkt(11'b01, 2, bc);
    repeat (4) @(negedge clk);
    chk(tx_ready, "R4 ready restored", tx_ready, 1);

    // R8: acknowledge becomes due while a data packet is on the wire.
    drive_pkt({1'b0, 8'h81, 2'b11}, 11, bc);
    wait_rx();
    chk(rx_valid && rx_data == 8'h81, "R6 held byte", rx_data, 8'h81);
    tx_data = 8'h3C; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    fork
      capture(bc, found, is_ack, d, stop_ok);
      begin
        repeat (30) @(negedge clk);
        take_rx();
      end
    join
    chk(found && !is_ack && d == 8'h3C && stop_ok, "R8 data packet intact", d, 8'h3C);
    measure_high(width);
    chk(width == bc, "R8 ack follows data", width, bc);
    drive_pkt(11'b01, 2, bc);
    repeat (4) @(negedge clk);
    chk(tx_ready && !rx_valid, "R8 end state", {tx_ready, rx_valid}, 2'b10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule